// File: doc/BRIEF.md
# Byte-Serial AES-128 Encryption Engine

This block encrypts one 128-bit block with AES-128 using a datapath only one byte wide. A single-cycle start pulse begins the transfer: the plaintext and key arrive one byte per clock, and the first key-addition is folded into the load. Ten rounds then run one after another. Each round pushes every state byte through one substitution unit and computes the next round key byte by byte with a second substitution unit. The ciphertext leaves one byte per clock, with a valid flag beside it.

The round state sits in two banks of a small byte memory. A round reads one bank in ShiftRows order, gathers four substituted bytes into a column, mixes the column, and hands it to a parallel-to-serial register. Each byte then gets its round-key byte added and is written into the other bank. The banks swap at the end of every round. Each round takes 20 clocks: 16 substitutions plus 4 clocks to drain the last column.

Top module: `aes8_core`

## Requirements
- R1: While `rst` is high and in the cycle after it, `ct_valid` is low and `ct_byte` is zero.
- R2: A start is accepted when `blk_start` is high in a clock edge while the engine is idle. Plaintext and key byte 0 are sampled at that same edge, and bytes 1 to 15 at the following 15 edges. Byte k is row k mod 4, column k div 4 of the AES state, so byte 0 is the first byte of the FIPS-197 hex string.
- R3: The 16 output bytes equal the AES-128 forward encryption of the loaded plaintext under the loaded key, in the same byte order as the input. Key 000102..0f and plaintext 00112233..ff give 69c4e0d86a7b0430d8cdb78070b4c55a.
- R4: `ct_valid` is first high after the edge 216 clocks after the accepting edge. It stays high for exactly 16 consecutive clocks carrying bytes 0 to 15, and is low at all other times.
- R5: `blk_start` and the data inputs are ignored from the accepting edge until the last output byte is presented. A start pulse during load, rounds or output leaves the result and its timing unchanged.
- R6: `ct_byte` is zero whenever `ct_valid` is low.
- R7: A synchronous reset in the middle of a block abandons it: no output bytes appear for that block, and the next started block encrypts correctly.
- R8: Rounds 1 to 9 apply SubBytes, ShiftRows, MixColumns and AddRoundKey. Round 10 omits MixColumns. The round constants run 01,02,04,08,10,20,40,80,1b,36, one per round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| blk_start | input | 1 | Start pulse, sampled with byte 0 |
| pt_byte | input | 8 | Plaintext byte stream |
| key_byte | input | 8 | Key byte stream |
| ct_byte | output | 8 | Registered ciphertext byte |
| ct_valid | output | 1 | Registered flag: `ct_byte` carries a ciphertext byte |

## Verification
Relative to the edge that accepts the start, input byte k is consumed at edge k. Output byte j is registered at edge 216+j and stays until edge 217+j. The bench drives and samples on the falling clock, so at the falling edge after edge m it expects `ct_valid` exactly for m from 216 to 231 and the byte m-216 inside that window. Every cycle of a block is compared against this window, including cycles with stray start pulses and the quiet cycles after a mid-block reset, so a latency off by one cycle fails as surely as a wrong byte.

// File: rtl/aes8_pkg.sv
`timescale 1ns/1ps
package aes8_pkg;
  localparam int BYTE_W     = 8;
  localparam int BLK_BYTES  = 16;
  localparam int COL_BYTES  = 4;
  localparam int NUM_ROUNDS = 10;
  localparam int IDX_W      = $clog2(BLK_BYTES);
  localparam int ROUND_CYC  = BLK_BYTES + COL_BYTES;
  localparam int PH_W       = $clog2(ROUND_CYC);
  localparam int RND_W      = $clog2(NUM_ROUNDS + 1);
  localparam int LATENCY    = BLK_BYTES + NUM_ROUNDS * ROUND_CYC;
  localparam int TBL_W      = BYTE_W * (1 << BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_ROUND, PH_EMIT} phase_e;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic byte_t xtime(input byte_t a);
    return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? 8'h1b : 8'h00);
  endfunction

  // substitution table built at elaboration: walk the multiplicative group
  // with generator 3 and its inverse in step, then apply the affine map
  function automatic logic [TBL_W-1:0] build_sbox();
    logic [TBL_W-1:0] t;
    byte_t p, q, x;
    t = '0;
    p = 8'h01;
    q = 8'h01;
    for (int n = 0; n < 255; n++) begin
      p = p ^ xtime(p);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'b0000};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      t[{p, 3'b000} +: BYTE_W] = x ^ 8'h63;
    end
    t[BYTE_W-1:0] = 8'h63;
    return t;
  endfunction
endpackage

// File: rtl/aes8_sbox.sv
`timescale 1ns/1ps
module aes8_sbox
  import aes8_pkg::*;
(
  input  byte_t din,
  output byte_t dout
);
  localparam logic [TBL_W-1:0] TBL = build_sbox();

  assign dout = TBL[{din, 3'b000} +: BYTE_W];
endmodule

// File: rtl/aes8_colser.sv
`timescale 1ns/1ps
module aes8_colser
  import aes8_pkg::*;
(
  input  logic  clk,
  input  logic  cap_en,
  input  logic  col_load,
  input  logic  bypass_mix,
  input  byte_t sub_byte,
  output byte_t ser_byte
);
  localparam int SH_W  = (COL_BYTES - 1) * BYTE_W;
  localparam int COL_W = COL_BYTES * BYTE_W;

  logic [SH_W-1:0]  gather_q;
  logic [COL_W-1:0] p2s_q;
  logic [COL_W-1:0] col_raw, col_mix, col_sel;
  byte_t            a [COL_BYTES];

  // three earlier bytes from the gather register, fourth straight from the S-box
  generate
    for (genvar i = 0; i < COL_BYTES - 1; i++) begin : g_gather
      assign a[i] = gather_q[i*BYTE_W +: BYTE_W];
    end
  endgenerate
  assign a[COL_BYTES-1] = sub_byte;

  // out[r] = 2*a[r] ^ 3*a[r+1] ^ a[r+2] ^ a[r+3]
  generate
    for (genvar r = 0; r < COL_BYTES; r++) begin : g_mix
      assign col_raw[r*BYTE_W +: BYTE_W] = a[r];
      assign col_mix[r*BYTE_W +: BYTE_W] =
          xtime(a[r] ^ a[(r+1)%COL_BYTES]) ^ a[(r+1)%COL_BYTES]
        ^ a[(r+2)%COL_BYTES] ^ a[(r+3)%COL_BYTES];
    end
  endgenerate

  assign col_sel  = bypass_mix ? col_raw : col_mix;
  assign ser_byte = p2s_q[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (cap_en) gather_q <= {sub_byte, gather_q[SH_W-1:BYTE_W]};
    if (col_load) p2s_q <= col_sel;
    else          p2s_q <= {{BYTE_W{1'b0}}, p2s_q[COL_W-1:BYTE_W]};
  end
endmodule

// File: rtl/aes8_keysched.sv
`timescale 1ns/1ps
module aes8_keysched
  import aes8_pkg::*;
(
  input  logic             clk,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  byte_t            ld_byte,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  byte_t            rcon,
  input  logic [IDX_W-1:0] rk_idx,
  output byte_t            rk_byte
);
  byte_t            kq [BLK_BYTES];
  byte_t            rot_byte, sub_byte, feed;
  logic [IDX_W-1:0] rot_idx;

  // last word, rotated by one byte, feeds the key S-box
  assign rot_idx  = {2'b11, upd_idx[1:0] + 2'd1};
  assign rot_byte = kq[rot_idx];

  aes8_sbox u_ksbox (.din(rot_byte), .dout(sub_byte));

  // first word mixes in the substituted word and rcon; later words chain on
  // the word just updated, which is also the round key byte being read out
  assign feed = (upd_idx < IDX_W'(COL_BYTES))
              ? (sub_byte ^ ((upd_idx == '0) ? rcon : 8'h00))
              : kq[upd_idx - IDX_W'(COL_BYTES)];

  assign rk_byte = kq[rk_idx];

  always_ff @(posedge clk) begin
    if (ld_en)       kq[ld_idx]  <= ld_byte;
    else if (upd_en) kq[upd_idx] <= kq[upd_idx] ^ feed;
  end
endmodule

// File: rtl/aes8_core.sv
`timescale 1ns/1ps
module aes8_core
  import aes8_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  blk_start,
  input  byte_t pt_byte,
  input  byte_t key_byte,
  output byte_t ct_byte,
  output logic  ct_valid
);
  localparam int MEM_AW = IDX_W + 1;

  phase_e           phase_q;
  logic [PH_W-1:0]  cnt_q;
  logic [RND_W-1:0] round_q;
  byte_t            rcon_q;
  logic             bank_q;

  byte_t            st_mem [2*BLK_BYTES];
  logic [IDX_W-1:0] rd_idx, ark_idx, cnt_idx;
  logic [1:0]       row_sel, col_sel;
  byte_t            rd_byte, sub_byte, ser_byte, rk_byte;
  logic             in_sub, in_ark, ld_en, col_load, last_round;
  logic             mem_we;
  logic [MEM_AW-1:0] mem_wa;
  byte_t            mem_wd;

  assign cnt_idx    = cnt_q[IDX_W-1:0];
  assign in_sub     = (phase_q == PH_ROUND) && (cnt_q < PH_W'(BLK_BYTES));
  assign in_ark     = (phase_q == PH_ROUND) && (cnt_q >= PH_W'(COL_BYTES));
  assign ark_idx    = IDX_W'(cnt_q - PH_W'(COL_BYTES));
  assign ld_en      = ((phase_q == PH_IDLE) && blk_start) || (phase_q == PH_LOAD);
  assign col_load   = in_sub && (cnt_q[1:0] == 2'b11);
  assign last_round = (round_q == RND_W'(NUM_ROUNDS));

  // ShiftRows as a read-address permutation: output byte (row r, col c)
  // comes from source column (c + r) mod 4 of the same row
  assign row_sel = cnt_q[1:0];
  assign col_sel = cnt_q[3:2];
  assign rd_idx  = (phase_q == PH_ROUND) ? {col_sel + row_sel, row_sel} : cnt_idx;
  assign rd_byte = st_mem[{bank_q, rd_idx}];

  aes8_sbox u_ssbox (.din(rd_byte), .dout(sub_byte));

  aes8_colser u_colser (
    .clk        (clk),
    .cap_en     (in_sub),
    .col_load   (col_load),
    .bypass_mix (last_round),
    .sub_byte   (sub_byte),
    .ser_byte   (ser_byte)
  );

  aes8_keysched u_keys (
    .clk     (clk),
    .ld_en   (ld_en),
    .ld_idx  (cnt_idx),
    .ld_byte (key_byte),
    .upd_en  (in_sub),
    .upd_idx (cnt_idx),
    .rcon    (rcon_q),
    .rk_idx  (ark_idx),
    .rk_byte (rk_byte)
  );

  // single write port: load fills bank 0, rounds fill the idle bank
  always_comb begin
    mem_we = 1'b0;
    mem_wa = '0;
    mem_wd = '0;
    if (ld_en) begin
      mem_we = 1'b1;
      mem_wa = {1'b0, cnt_idx};
      mem_wd = pt_byte ^ key_byte;
    end else if (in_ark) begin
      mem_we = 1'b1;
      mem_wa = {~bank_q, ark_idx};
      mem_wd = ser_byte ^ rk_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) st_mem[mem_wa] <= mem_wd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      round_q  <= '0;
      rcon_q   <= 8'h01;
      bank_q   <= 1'b0;
      ct_valid <= 1'b0;
      ct_byte  <= '0;
    end else begin
      ct_valid <= 1'b0;
      ct_byte  <= '0;
      case (phase_q)
        PH_IDLE: begin
          if (blk_start) begin
            phase_q <= PH_LOAD;
            cnt_q   <= PH_W'(1);
            bank_q  <= 1'b0;
          end
        end
        PH_LOAD: begin
          if (cnt_q == PH_W'(BLK_BYTES - 1)) begin
            phase_q <= PH_ROUND;
            cnt_q   <= '0;
            round_q <= RND_W'(1);
            rcon_q  <= 8'h01;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_ROUND: begin
          if (cnt_q == PH_W'(ROUND_CYC - 1)) begin
            cnt_q  <= '0;
            bank_q <= ~bank_q;
            if (last_round) begin
              phase_q <= PH_EMIT;
            end else begin
              round_q <= round_q + 1'b1;
              rcon_q  <= xtime(rcon_q);
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_EMIT: begin
          ct_valid <= 1'b1;
          ct_byte  <= rd_byte;
          if (cnt_q == PH_W'(BLK_BYTES - 1)) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            round_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aes8_core_chk.sv
`timescale 1ns/1ps
module aes8_core_chk
  import aes8_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             blk_start,
  input logic             ct_valid,
  input byte_t            ct_byte,
  input logic [RND_W-1:0] round_idx
);
  localparam int LAST  = LATENCY + BLK_BYTES - 1;
  localparam int CYC_W = $clog2(LAST + 1);
  localparam int RUN_W = $clog2(BLK_BYTES + 2);

  logic             act_q;
  logic [CYC_W-1:0] cyc_q;
  logic [RUN_W-1:0] run_q;

  // independent busy window: counts edges since the accepting edge
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      cyc_q <= '0;
      run_q <= '0;
    end else begin
      run_q <= ct_valid ? run_q + 1'b1 : '0;
      if (!act_q || cyc_q == CYC_W'(LAST)) begin
        act_q <= blk_start;
        cyc_q <= '0;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  AST_VALID_WINDOW: assert property (@(posedge clk) disable iff (rst)
    ct_valid == (act_q && cyc_q >= CYC_W'(LATENCY))); // R4

  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_W'(BLK_BYTES)); // R4

  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
    (act_q && cyc_q < CYC_W'(LATENCY) && blk_start) |=> !ct_valid); // R5

  AST_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ct_valid |-> (ct_byte == '0)); // R6

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> !ct_valid); // R1

  AST_ROUND_RANGE: assert property (@(posedge clk) disable iff (rst)
    round_idx <= RND_W'(NUM_ROUNDS)); // R8
endmodule

bind aes8_core aes8_core_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .blk_start (blk_start),
  .ct_valid  (ct_valid),
  .ct_byte   (ct_byte),
  .round_idx (round_q)
);

// File: tb/aes8_core_test.sv
`timescale 1ns/1ps
module aes8_core_test;
  logic       clk;
  logic       rst;
  logic       blk_start;
  logic [7:0] pt_byte;
  logic [7:0] key_byte;
  logic [7:0] ct_byte;
  logic       ct_valid;

  int checks = 0;
  int errors = 0;

  logic [7:0] sb_ref [256];

  aes8_core uut (
    .clk       (clk),
    .rst       (rst),
    .blk_start (blk_start),
    .pt_byte   (pt_byte),
    .key_byte  (key_byte),
    .ct_byte   (ct_byte),
    .ct_valid  (ct_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [7:0] gb(input logic [127:0] v, input int k);
    return v[127 - 8*k -: 8];
  endfunction

  // reference cipher from the standard definition, byte 0 = most significant
  function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [127:0] key);
    logic [127:0] s, k, t, kn;
    logic [7:0]   rc, a0, a1, a2, a3;
    s  = pt ^ key;
    k  = key;
    rc = 8'h01;
    for (int rnd = 1; rnd <= 10; rnd++) begin
      for (int j = 0; j < 16; j++) begin
        int rw = j % 4;
        int c  = j / 4;
        t[127 - 8*j -: 8] = sb_ref[gb(s, 4*((c + rw) % 4) + rw)];
      end
      if (rnd < 10) begin
        for (int c = 0; c < 4; c++) begin
          a0 = gb(t, 4*c); a1 = gb(t, 4*c+1); a2 = gb(t, 4*c+2); a3 = gb(t, 4*c+3);
          t[127 - 8*(4*c)   -: 8] = gmul(a0,2) ^ gmul(a1,3) ^ a2 ^ a3;
          t[127 - 8*(4*c+1) -: 8] = a0 ^ gmul(a1,2) ^ gmul(a2,3) ^ a3;
          t[127 - 8*(4*c+2) -: 8] = a0 ^ a1 ^ gmul(a2,2) ^ gmul(a3,3);
          t[127 - 8*(4*c+3) -: 8] = gmul(a0,3) ^ a1 ^ a2 ^ gmul(a3,2);
        end
      end
      for (int i = 0; i < 4; i++)
        kn[127 - 8*i -: 8] = gb(k, i) ^ sb_ref[gb(k, 12 + (i+1)%4)] ^ ((i == 0) ? rc : 8'h00);
      for (int i = 4; i < 16; i++)
        kn[127 - 8*i -: 8] = gb(k, i) ^ gb(kn, i-4);
      k  = kn;
      rc = gmul(rc, 8'h02);
      s  = t ^ k;
    end
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one block; pokes are cycles (after the accepting edge) with a stray start
  task automatic run_block(input logic [127:0] pt, input logic [127:0] key,
                           input int poke_a, input int poke_b, input string req);
    logic [127:0] exp;
    exp = ref_enc(pt, key);
    @(negedge clk);
    blk_start = 1'b1;
    pt_byte   = gb(pt, 0);
    key_byte  = gb(key, 0);
    for (int n = 1; n <= 234; n++) begin
      int  m;
      bit  exp_v;
      @(negedge clk);
      m     = n - 1;
      exp_v = (m >= 216) && (m <= 231);
      chk(ct_valid === exp_v, "R4", "valid window", {127'b0, ct_valid}, {127'b0, exp_v});
      if (exp_v)
        chk(ct_byte === gb(exp, m - 216), req, "cipher byte", {120'b0, ct_byte}, {120'b0, gb(exp, m - 216)});
      else
        chk(ct_byte === 8'h00, "R6", "idle output", {120'b0, ct_byte}, 128'h0);
      blk_start = (n == poke_a) || (n == poke_b);
      if (n < 16) begin
        pt_byte  = gb(pt, n);
        key_byte = gb(key, n);
      end else begin
        pt_byte  = 8'($urandom);
        key_byte = 8'($urandom);
      end
    end
    blk_start = 1'b0;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL R4 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] fips_key, fips_pt;
    void'($urandom(32'h00C0FFEE));
    // reference S-box by brute-force inversion plus affine map
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 8'h00;
      for (int y = 1; y < 256; y++)
        if (gmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      sb_ref[x] = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    end

    rst = 1'b1; blk_start = 1'b0; pt_byte = '0; key_byte = '0;
    repeat (3) @(negedge clk);
    chk(ct_valid === 1'b0, "R1", "valid in reset", {127'b0, ct_valid}, 128'h0);
    chk(ct_byte === 8'h00, "R1", "byte in reset", {120'b0, ct_byte}, 128'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(ct_valid === 1'b0, "R1", "valid after reset", {127'b0, ct_valid}, 128'h0);

    // published vector: full ten-round schedule and final-round form (R8)
    fips_key = 128'h000102030405060708090a0b0c0d0e0f;
    fips_pt  = 128'h00112233445566778899aabbccddeeff;
    chk(ref_enc(fips_pt, fips_key) === 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R8",
        "known vector", ref_enc(fips_pt, fips_key), 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    run_block(fips_pt, fips_key, 0, 0, "R3");

    // byte ordering: zero key, counting plaintext, and its byte reversal
    run_block(128'h000102030405060708090a0b0c0d0e0f, 128'h0, 0, 0, "R2");
    run_block(128'h0f0e0d0c0b0a09080706050403020100, 128'h0, 0, 0, "R2");
    // all-ones corner
    run_block({128{1'b1}}, {128{1'b1}}, 0, 0, "R3");

    for (int b = 0; b < 10; b++)
      run_block(rnd128(), rnd128(), 0, 0, "R3");

    // stray starts in load, rounds and output phases
    run_block(rnd128(), rnd128(), 5, 100, "R5");
    run_block(rnd128(), rnd128(), 150, 220, "R5");
    run_block(fips_pt, fips_key, 1, 217, "R5");

    // reset in the middle of a block
    @(negedge clk);
    blk_start = 1'b1; pt_byte = 8'h5a; key_byte = 8'ha5;
    @(negedge clk);
    blk_start = 1'b0;
    repeat (60) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int n = 0; n < 240; n++) begin
      @(negedge clk);
      chk(ct_valid === 1'b0, "R7", "output after abort", {127'b0, ct_valid}, 128'h0);
    end
    run_block(fips_pt, fips_key, 0, 0, "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule